// File: doc/BRIEF.md
# Priority Task Dispatcher

This block tracks which tasks have a registered input action, a registered body and a registered output action, each as a bit vector with one bit per task. A release request for a task marks its input and its body. A finish request marks its output. When a dispatch command arrives, the block first emits one strobe for every registered output and then one for every registered input. Each strobe carries a task index. Emitting the outputs first means a value produced at an instant is handed on before any consumer samples its inputs at that same instant.

After both drains, the block picks the registered body with the highest priority. It makes that task the running task only when the new task outranks the one already running. A task-exit input retires the running task and pulses a ready flag with that task's index. The block never executes task code: it only sequences the I/O actions and chooses which task runs.

Top module: `task_dispatcher`

## Requirements
- R1: A release request for task i registers both an input action and a body for task i. The input action later appears as an input strobe with index i, and the body becomes a candidate for selection.
- R2: A finish request for task i registers an output action for task i, which later appears as an output strobe with index i.
- R3: During a dispatch, every output strobe comes before the first input strobe. Within each group, strobes are issued one per clock cycle in ascending task index.
- R4: A registered action is cleared in the cycle its strobe is issued. A later dispatch with no new requests emits no strobe.
- R5: After the drains, the registered body with the lowest index is chosen (index 0 is the highest priority). It becomes the running task when no task is running, or when its index is strictly lower than the running index. In the second case `preemptPulse` is high for one cycle and `runIdx` shows the new task. Otherwise the running task is kept.
- R6: A task exit while a task is running clears that task's body and `runValid`. It also raises `readyPulse` for one cycle with `readyIdx` equal to the retired index. The retired task is not selected again unless it is released again.
- R7: `busy` is high from the cycle after an accepted dispatch command until the selection step completes. Release, finish and exit requests seen while busy are held. They take effect once the block is idle again and are not part of the dispatch in progress.
- R8: A dispatch command while busy is ignored. An exit request while no task is running produces no ready pulse.
- R9: After reset, all vectors are empty, `busy` and `runValid` are low, and no strobe or pulse is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| relReq | input | 1 | Release request |
| relIdx | input | 4 | Task index for release |
| finReq | input | 1 | Finish request |
| finIdx | input | 4 | Task index for finish |
| dispatchCmd | input | 1 | Start a dispatch (ignored while busy) |
| exitReq | input | 1 | Running task has exited |
| outStrobe | output | 1 | Output action strobe |
| outIdx | output | 4 | Task index of output strobe |
| inStrobe | output | 1 | Input action strobe |
| inIdx | output | 4 | Task index of input strobe |
| busy | output | 1 | Dispatch in progress |
| runValid | output | 1 | A task is running |
| runIdx | output | 4 | Running task index |
| preemptPulse | output | 1 | Running task displaced by a higher-priority one |
| readyPulse | output | 1 | Running task retired |
| readyIdx | output | 4 | Index of retired task |

## Verification
The assertions assume that a release for a task never arrives in the same idle cycle as that task's own exit, so the exit and the re-registration never compete for one body bit. The stimulus raises one request per task at a time and keeps release and exit for the same index in different cycles. The assertions also take every request index to lie inside the task count. With the default of 16 tasks and 4-bit index ports, every index the stimulus can drive is in range. Held requests are raised only while `busy` is high, so the point where they take effect is set by the dispatch sequence alone.

// File: rtl/dispatcher_pkg.sv
package dispatcher_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_OUT, ST_IN, ST_SEL} dispState_e;

  typedef struct packed {
    logic applyReq;
    logic popOut;
    logic popIn;
    logic doSelect;
  } dispCtrl_t;
endpackage

// File: rtl/disp_prio_enc.sv
module disp_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Lowest set index wins
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/disp_control.sv
module disp_control
  import dispatcher_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dispatchCmd,
  input  logic      outAny,
  input  logic      inAny,
  output dispCtrl_t ctrl,
  output logic      busy
);
  dispState_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        ctrl.applyReq = 1'b1;
        if (dispatchCmd) stateNext = ST_OUT;
      end
      ST_OUT: begin
        if (outAny) ctrl.popOut = 1'b1;
        else        stateNext   = ST_IN;
      end
      ST_IN: begin
        if (inAny) ctrl.popIn = 1'b1;
        else       stateNext  = ST_SEL;
      end
      default: begin
        ctrl.doSelect = 1'b1;
        stateNext     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(dispatchCmd));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dispatchCmd && state != ST_SEL) |=> busy);
endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import dispatcher_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dispCtrl_t        ctrl,
  input  logic             relReq,
  input  logic [IDX_W-1:0] relIdx,
  input  logic             finReq,
  input  logic [IDX_W-1:0] finIdx,
  input  logic             exitReq,
  output logic             outAny,
  output logic             inAny,
  output logic             outStrobe,
  output logic [IDX_W-1:0] outIdx,
  output logic             inStrobe,
  output logic [IDX_W-1:0] inIdx,
  output logic             runValid,
  output logic [IDX_W-1:0] runIdx,
  output logic             preemptPulse,
  output logic             readyPulse,
  output logic [IDX_W-1:0] readyIdx
);
  logic [N-1:0] pendIn, pendOut, pendBody, holdRel, holdFin;
  logic [N-1:0] inN, outN, bodyN, holdRelN, holdFinN, relVec, finVec;
  logic         holdExit, holdExitN, runVN, preemptN, readyN;
  logic [IDX_W-1:0] runIdxN, readyIdxN, bodyIdx;
  logic         bodyAny;

  disp_prio_enc #(.N(N), .IDX_W(IDX_W)) u_encOut  (.vec(pendOut),  .any(outAny),  .idx(outIdx));
  disp_prio_enc #(.N(N), .IDX_W(IDX_W)) u_encIn   (.vec(pendIn),   .any(inAny),   .idx(inIdx));
  disp_prio_enc #(.N(N), .IDX_W(IDX_W)) u_encBody (.vec(pendBody), .any(bodyAny), .idx(bodyIdx));

  assign relVec    = relReq ? (N'(1) << relIdx) : '0;
  assign finVec    = finReq ? (N'(1) << finIdx) : '0;
  assign outStrobe = ctrl.popOut;
  assign inStrobe  = ctrl.popIn;

  always_comb begin
    inN = pendIn;  outN = pendOut;  bodyN = pendBody;
    holdRelN = holdRel;  holdFinN = holdFin;  holdExitN = holdExit;
    runVN = runValid;  runIdxN = runIdx;
    preemptN = 1'b0;  readyN = 1'b0;  readyIdxN = readyIdx;
    if (ctrl.applyReq) begin
      if ((exitReq || holdExit) && runValid) begin
        bodyN[runIdx] = 1'b0;
        runVN         = 1'b0;
        readyN        = 1'b1;
        readyIdxN     = runIdx;
      end
      holdExitN = 1'b0;
      inN       = inN | holdRel | relVec;
      bodyN     = bodyN | holdRel | relVec;
      outN      = outN | holdFin | finVec;
      holdRelN  = '0;
      holdFinN  = '0;
    end else begin
      holdRelN  = holdRel | relVec;
      holdFinN  = holdFin | finVec;
      holdExitN = holdExit | exitReq;
    end
    if (ctrl.popOut) outN[outIdx] = 1'b0;
    if (ctrl.popIn)  inN[inIdx]   = 1'b0;
    if (ctrl.doSelect && bodyAny && (!runValid || bodyIdx < runIdx)) begin
      runVN    = 1'b1;
      runIdxN  = bodyIdx;
      preemptN = runValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendIn <= '0;  pendOut <= '0;  pendBody <= '0;
      holdRel <= '0;  holdFin <= '0;  holdExit <= 1'b0;
      runValid <= 1'b0;  runIdx <= '0;
      preemptPulse <= 1'b0;  readyPulse <= 1'b0;  readyIdx <= '0;
    end else begin
      pendIn <= inN;  pendOut <= outN;  pendBody <= bodyN;
      holdRel <= holdRelN;  holdFin <= holdFinN;  holdExit <= holdExitN;
      runValid <= runVN;  runIdx <= runIdxN;
      preemptPulse <= preemptN;  readyPulse <= readyN;  readyIdx <= readyIdxN;
    end
  end

  // R3
  out_before_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |-> !outAny);

  // R4
  out_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    outStrobe |=> !pendOut[$past(outIdx)]);

  // R4
  in_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |=> !pendIn[$past(inIdx)]);

  // R5
  preempt_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    preemptPulse |-> (runValid && runIdx < $past(runIdx)));

  // R5
  running_registered_chk: assert property (@(posedge clk) disable iff (!rstN)
    runValid |-> pendBody[runIdx]);

  // R6
  ready_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |-> (!runValid && readyIdx == $past(runIdx)));

  // R6
  run_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runValid) |-> readyPulse);
endmodule

// File: rtl/task_dispatcher.sv
module task_dispatcher
  import dispatcher_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  localparam int IDX_W    = $clog2(NUM_TASKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             relReq,
  input  logic [IDX_W-1:0] relIdx,
  input  logic             finReq,
  input  logic [IDX_W-1:0] finIdx,
  input  logic             dispatchCmd,
  input  logic             exitReq,
  output logic             outStrobe,
  output logic [IDX_W-1:0] outIdx,
  output logic             inStrobe,
  output logic [IDX_W-1:0] inIdx,
  output logic             busy,
  output logic             runValid,
  output logic [IDX_W-1:0] runIdx,
  output logic             preemptPulse,
  output logic             readyPulse,
  output logic [IDX_W-1:0] readyIdx
);
  dispCtrl_t ctrl;
  logic      outAny, inAny;

  disp_control u_ctrl (
    .clk(clk), .rstN(rstN), .dispatchCmd(dispatchCmd),
    .outAny(outAny), .inAny(inAny), .ctrl(ctrl), .busy(busy)
  );

  disp_datapath #(.N(NUM_TASKS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .relReq(relReq), .relIdx(relIdx), .finReq(finReq), .finIdx(finIdx),
    .exitReq(exitReq), .outAny(outAny), .inAny(inAny),
    .outStrobe(outStrobe), .outIdx(outIdx), .inStrobe(inStrobe), .inIdx(inIdx),
    .runValid(runValid), .runIdx(runIdx), .preemptPulse(preemptPulse),
    .readyPulse(readyPulse), .readyIdx(readyIdx)
  );
endmodule

// File: tb/task_dispatcher_tb.sv
module task_dispatcher_tb;
  localparam int N = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic relReq = 1'b0, finReq = 1'b0, dispatchCmd = 1'b0, exitReq = 1'b0;
  logic [3:0] relIdx = '0, finIdx = '0;
  logic outStrobe, inStrobe, busy, runValid, preemptPulse, readyPulse;
  logic [3:0] outIdx, inIdx, runIdx, readyIdx;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { int kind; int idx; string tag; } ev_t;
  ev_t q[$];

  logic [N-1:0] mIn = '0, mOut = '0, mBody = '0;
  bit mRunV = 1'b0;
  int mRun = 0;

  always #10 clk = ~clk;

  task_dispatcher u_dut (
    .clk(clk), .rstN(rstN), .relReq(relReq), .relIdx(relIdx),
    .finReq(finReq), .finIdx(finIdx), .dispatchCmd(dispatchCmd), .exitReq(exitReq),
    .outStrobe(outStrobe), .outIdx(outIdx), .inStrobe(inStrobe), .inIdx(inIdx),
    .busy(busy), .runValid(runValid), .runIdx(runIdx), .preemptPulse(preemptPulse),
    .readyPulse(readyPulse), .readyIdx(readyIdx)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic pushEv(int kind, int idx, string tag);
    ev_t e;
    e.kind = kind; e.idx = idx; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: kind 0 out strobe, 1 in strobe, 2 ready, 3 preempt
  task automatic compareEv(int kind, int idx);
    ev_t e;
    if (q.size() == 0) begin
      check(1'b0, "R8", $sformatf("unexpected event kind %0d", kind), idx, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == kind, e.tag, "event kind", kind, e.kind);
      check(e.idx == idx, e.tag, "event index", idx, e.idx);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (outStrobe)    compareEv(0, int'(outIdx));
      if (inStrobe)     compareEv(1, int'(inIdx));
      if (readyPulse)   compareEv(2, int'(readyIdx));
      if (preemptPulse) compareEv(3, int'(runIdx));
    end
  end

  // expected dispatch sequence from the model (R3, R5)
  task automatic expectDispatch();
    int best;
    for (int i = 0; i < N; i++) if (mOut[i]) pushEv(0, i, "R3");
    for (int i = 0; i < N; i++) if (mIn[i])  pushEv(1, i, "R3");
    mOut = '0; mIn = '0;
    best = -1;
    for (int i = N - 1; i >= 0; i--) if (mBody[i]) best = i;
    if (best >= 0 && (!mRunV || best < mRun)) begin
      if (mRunV) pushEv(3, best, "R5");
      mRunV = 1'b1; mRun = best;
    end
  endtask

  task automatic doRelease(int i);
    relReq = 1'b1; relIdx = 4'(i);
    @(posedge clk); #1;
    relReq = 1'b0;
    mIn[i] = 1'b1; mBody[i] = 1'b1;
  endtask

  task automatic doFinish(int i);
    finReq = 1'b1; finIdx = 4'(i);
    @(posedge clk); #1;
    finReq = 1'b0;
    mOut[i] = 1'b1;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 100 && busy; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic doDispatch();
    expectDispatch();
    dispatchCmd = 1'b1;
    @(posedge clk); #1;
    dispatchCmd = 1'b0;
    check(busy == 1'b1, "R7", "busy after dispatch", busy, 1);
    waitIdle();
    @(posedge clk); #1;
    check(runValid == mRunV, "R5", "runValid", runValid, mRunV);
    if (mRunV) check(int'(runIdx) == mRun, "R5", "runIdx", runIdx, mRun);
  endtask

  task automatic doExit();
    if (mRunV) begin
      pushEv(2, mRun, "R6");
      mBody[mRun] = 1'b0; mRunV = 1'b0;
    end
    exitReq = 1'b1;
    @(posedge clk); #1;
    exitReq = 1'b0;
    @(posedge clk); #1;
    check(runValid == 1'b0, "R6", "runValid after exit", runValid, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset state
    check(busy == 1'b0, "R9", "busy at reset", busy, 0);
    check(runValid == 1'b0, "R9", "runValid at reset", runValid, 0);
    check(outStrobe == 1'b0 && inStrobe == 1'b0, "R9", "strobes at reset", outStrobe | inStrobe, 0);
    doDispatch();                       // R9 empty dispatch: no events
    // R1 R2 R3: mixed registrations, ascending drains, outputs first
    doRelease(5); doRelease(2); doFinish(9); doFinish(1);
    doDispatch();
    // R4: nothing left
    doDispatch();
    // R5: lower priority does not displace
    doRelease(7);
    doDispatch();
    // R5: higher priority preempts
    doRelease(0);
    doDispatch();
    // R6: exit then reselect
    doExit();
    doDispatch();
    // R7 R8: requests and a second dispatch while busy
    doRelease(3);
    expectDispatch();
    dispatchCmd = 1'b1;
    @(posedge clk); #1;
    check(busy == 1'b1, "R7", "busy during drain", busy, 1);
    finReq = 1'b1; finIdx = 4'd4; relReq = 1'b1; relIdx = 4'd1; // held
    @(posedge clk); #1;
    finReq = 1'b0; relReq = 1'b0; dispatchCmd = 1'b0;
    waitIdle();
    @(posedge clk); #1;
    check(busy == 1'b0, "R8", "dispatch while busy ignored", busy, 0);
    check(int'(runIdx) == mRun, "R7", "held release not selected yet", runIdx, mRun);
    mOut[4] = 1'b1; mIn[1] = 1'b1; mBody[1] = 1'b1;
    doDispatch();                       // R7 held requests now drained
    // R8: exit with nothing running
    doExit();
    doExit();
    repeat (3) @(posedge clk);
    #1 check(q.size() == 0, "R4", "outstanding expected events", q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule